// File: doc/BRIEF.md
# Half-Duplex Serial Link Turnaround Controller

This block is the host end of a single-wire, bit-synchronous debug link. It shares one data line with a target. The line is split into a drive value, a drive enable and a sampled input. One bit moves per cycle of `clk_i`. The host serializes command bytes into frames. When a command expects an answer, the host hands the line to the target and waits for the reply frame. It then takes the line back and drives idle bits for a programmable guard time before it accepts the next byte.

A frame is 12 bit periods long: a low start bit, eight data bits sent least significant bit first, an even parity bit, and two high stop bits. An idle bit is a high level. While the host listens, it ignores the target's own guard idle bits and starts receiving at the first low sample. If no start bit arrives within a bounded window, the host gives up and takes the line back. A run of one full frame time of low samples marks a line BREAK, which is held until software clears it.

Top module: `hd_link_ctrl`

## Requirements
- R1: During and right after reset, `line_oe_o`=1, `line_o`=1, `tx_ready_o`=1, and `rx_valid_o`, `timeout_o` and `break_o` are 0.
- R2: A byte accepted on `tx_valid_i`&`tx_ready_o` is driven from the next cycle on, one bit per cycle, with `line_oe_o` high. Bit 0 is low (start), bits 1..8 carry data LSB first, bit 9 is parity, and bits 10 and 11 are high (stops).
- R3: The transmitted parity bit equals the XOR of the 8 data bits (even parity).
- R4: If `tx_expect_i` was high at accept, the host drives one more high bit after the last stop bit and then drops `line_oe_o`. Otherwise `line_oe_o` stays high and `tx_ready_o` is high in the cycle after the last stop bit.
- R5: While the line is released, high samples (the target's guard idle bits) are ignored. Reception starts at the first low sample, and the line stays released until that frame ends or the timeout expires.
- R6: A received frame whose two stop samples are high produces a one-cycle `rx_valid_o` in the cycle after the last stop sample, with the data assembled LSB first on `rx_data_o`.
- R7: `rx_parity_err_o` is high together with `rx_valid_o` exactly when the received parity bit differs from the XOR of the received data bits.
- R8: If no low sample arrives within TIMEOUT_BITS cycles of release (`line_oe_o` low for exactly TIMEOUT_BITS cycles), `timeout_o` pulses for one cycle as the host takes the line back.
- R9: After the host takes the line back (following a reply or a timeout), it drives high with `tx_ready_o` low for exactly G cycles, where G = `guard_bits_i`, or 1 when `guard_bits_i` is 0. `tx_ready_o` then rises.
- R10: Twelve consecutive low samples while the line is released set `break_o`. The flag stays set until `break_clr_i` is pulsed. A frame with a low stop sample sets neither `rx_valid_o` nor, unless it is all low, `break_o`.
- R11: `tx_ready_o` is low while sending, holding, listening, receiving and during the guard time. `tx_valid_i` is ignored then, and no frame is sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_o | output | 1 | Data line drive value |
| line_oe_o | output | 1 | Data line drive enable (host owns line) |
| line_i | input | 1 | Sampled data line |
| tx_valid_i | input | 1 | Byte to send is valid |
| tx_data_i | input | DATA_W | Byte to send |
| tx_expect_i | input | 1 | Command expects a response frame |
| tx_ready_o | output | 1 | Host can accept a byte |
| rx_valid_o | output | 1 | Received byte valid (one cycle) |
| rx_data_o | output | DATA_W | Received byte |
| rx_parity_err_o | output | 1 | Parity mismatch on received byte |
| guard_bits_i | input | GUARD_W | Idle bits inserted when regaining the line |
| timeout_o | output | 1 | Response wait expired (one cycle) |
| break_o | output | 1 | Sticky BREAK flag |
| break_clr_i | input | 1 | Clears the BREAK flag |

## Verification
The hardest situations to reach are those where the line belongs to the target: a release that times out, a reply with a low stop sample, and an all-low BREAK. Each needs the host first to send a command that expects a reply. A behavioural target model then watches for `line_oe_o` to fall. It waits a chosen number of idle bits and drives a raw 12-bit pattern, which can be a clean frame, a corrupt frame or a BREAK, or it stays silent. The guard length is measured from the cycle the host takes the line back until `tx_ready_o` rises, at several values of `guard_bits_i`, including zero.

// File: rtl/hd_link_pkg.sv
package hd_link_pkg;
  typedef enum logic [2:0] {
    ST_READY,
    ST_SEND,
    ST_HOLD,
    ST_LISTEN,
    ST_RECV,
    ST_GUARD
  } link_state_e;

  // start + data + parity + two stops
  function automatic int frame_bits(input int dw);
    return dw + 4;
  endfunction
endpackage

// File: rtl/hd_link_tx.sv
module hd_link_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              busy_o,
  output logic              last_o
);
  localparam int FB = hd_link_pkg::frame_bits(DATA_W);
  localparam int CW = $clog2(FB);

  logic [FB-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i && !busy_o) begin
      sh_q   <= {2'b11, ^data_i, data_i, 1'b0};
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      sh_q <= {1'b1, sh_q[FB-1:1]};
      if (cnt_q == CW'(FB-1)) busy_o <= 1'b0;
      else                    cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = busy_o ? sh_q[0] : 1'b1;
  assign last_o = busy_o && (cnt_q == CW'(FB-1));

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> !bit_o);
  p_stop_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> bit_o);
endmodule

// File: rtl/hd_link_rx.sv
module hd_link_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              mon_i,
  input  logic              line_i,
  input  logic              brk_clr_i,
  output logic              done_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              break_o
);
  localparam int FB = hd_link_pkg::frame_bits(DATA_W);
  localparam int CW = $clog2(FB);

  logic              busy_q, par_q, stp_q;
  logic [CW-1:0]     cnt_q, lo_q;
  logic [DATA_W-1:0] sh_q;

  assign done_o = busy_q && (cnt_q == CW'(FB-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      stp_q   <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!busy_q) begin
        if (arm_i && !line_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(1);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q <= CW'(DATA_W))        sh_q  <= {line_i, sh_q[DATA_W-1:1]};
        else if (cnt_q == CW'(DATA_W+1)) par_q <= line_i;
        else if (cnt_q == CW'(DATA_W+2)) stp_q <= line_i;
        if (done_o) begin
          busy_q  <= 1'b0;
          valid_o <= stp_q && line_i;
          data_o  <= sh_q;
          perr_o  <= (^sh_q) ^ par_q;
        end
      end
    end
  end

  // consecutive low samples while the target owns the line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      break_o <= 1'b0;
    end else begin
      if (!mon_i || line_i)            lo_q <= '0;
      else if (lo_q != CW'(FB-1))      lo_q <= lo_q + 1'b1;
      if (mon_i && !line_i && lo_q == CW'(FB-1)) break_o <= 1'b1;
      else if (brk_clr_i)                        break_o <= 1'b0;
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_break_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_o && !brk_clr_i) |=> break_o);
endmodule

// File: rtl/hd_link_ctrl.sv
module hd_link_ctrl #(
  parameter int DATA_W       = 8,
  parameter int GUARD_W      = 3,
  parameter int TIMEOUT_BITS = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               line_o,
  output logic               line_oe_o,
  input  logic               line_i,
  input  logic               tx_valid_i,
  input  logic [DATA_W-1:0]  tx_data_i,
  input  logic               tx_expect_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               rx_parity_err_o,
  input  logic [GUARD_W-1:0] guard_bits_i,
  output logic               timeout_o,
  output logic               break_o,
  input  logic               break_clr_i
);
  import hd_link_pkg::*;

  localparam int TMR_MAX = (TIMEOUT_BITS > (1 << GUARD_W)) ? TIMEOUT_BITS : (1 << GUARD_W);
  localparam int TW      = $clog2(TMR_MAX + 1);

  link_state_e st_q;
  logic [TW-1:0] tmr_q, g_eff;
  logic exp_q, tx_load, tx_bit, tx_busy, tx_last, rx_done, listening;

  assign tx_ready_o = (st_q == ST_READY);
  assign tx_load    = tx_ready_o && tx_valid_i;
  assign listening  = (st_q == ST_LISTEN) || (st_q == ST_RECV);
  assign line_oe_o  = !listening;
  assign line_o     = tx_bit;
  assign g_eff      = (guard_bits_i == '0) ? TW'(1) : TW'(guard_bits_i);

  hd_link_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (tx_data_i),
    .bit_o  (tx_bit),
    .busy_o (tx_busy),
    .last_o (tx_last)
  );

  hd_link_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (st_q == ST_LISTEN),
    .mon_i     (listening),
    .line_i    (line_i),
    .brk_clr_i (break_clr_i),
    .done_o    (rx_done),
    .valid_o   (rx_valid_o),
    .data_o    (rx_data_o),
    .perr_o    (rx_parity_err_o),
    .break_o   (break_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_READY;
      tmr_q     <= '0;
      exp_q     <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      unique case (st_q)
        ST_READY: if (tx_valid_i) begin
          exp_q <= tx_expect_i;
          st_q  <= ST_SEND;
        end
        ST_SEND: if (tx_last) st_q <= exp_q ? ST_HOLD : ST_READY;
        ST_HOLD: begin
          tmr_q <= '0;
          st_q  <= ST_LISTEN;
        end
        ST_LISTEN: begin
          if (!line_i) st_q <= ST_RECV;
          else if (tmr_q == TW'(TIMEOUT_BITS-1)) begin
            timeout_o <= 1'b1;
            tmr_q     <= '0;
            st_q      <= ST_GUARD;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_RECV: if (rx_done) begin
          tmr_q <= '0;
          st_q  <= ST_GUARD;
        end
        ST_GUARD: begin
          if (tmr_q >= g_eff - 1'b1) st_q <= ST_READY;
          else                       tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= ST_READY;
      endcase
    end
  end

  p_release_after_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_oe_o) |-> $past(line_o));
  p_ready_owns_line_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (line_oe_o && line_o && !tx_busy));
  p_guard_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_oe_o) |-> !tx_ready_o);
  p_timeout_regain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (line_oe_o && !tx_ready_o && $past(!line_oe_o)));
endmodule

// File: tb/sim_hd_link_ctrl.sv
`timescale 1ns/1ps
module sim_hd_link_ctrl;
  localparam int DW = 8, GW = 3, TO = 40, FB = DW + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic line, line_oe, line_in = 1'b1;
  logic tx_valid = 1'b0, tx_expect = 1'b0, tx_ready;
  logic [DW-1:0] tx_data = '0, rx_data;
  logic rx_valid, rx_perr, timeout, brk, brk_clr = 1'b0;
  logic [GW-1:0] guard = 3'd2;

  hd_link_ctrl #(.DATA_W(DW), .GUARD_W(GW), .TIMEOUT_BITS(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_o(line), .line_oe_o(line_oe), .line_i(line_in),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_expect_i(tx_expect), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_parity_err_o(rx_perr),
    .guard_bits_i(guard), .timeout_o(timeout), .break_o(brk), .break_clr_i(brk_clr));

  typedef struct { logic [DW-1:0] d; logic exp; } txe_t;
  txe_t txq[$];
  logic [DW:0] rxq[$];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // host-side frame monitor (scoreboard consumer)
  always begin : mon_tx
    logic [FB-1:0] f;
    logic oe_ok;
    txe_t e;
    @(negedge clk);
    if (rst_n && line_oe && !line && !tx_ready) begin
      f[0] = line; oe_ok = 1'b1;
      for (int i = 1; i < FB; i++) begin @(negedge clk); f[i] = line; oe_ok &= line_oe; end
      if (txq.size() == 0) chk(0, "R11", "frame without accepted byte", int'(f), 0);
      else begin
        e = txq.pop_front();
        chk(f[DW:1] == e.d && oe_ok, "R2", "data bits", int'(f[DW:1]), int'(e.d));
        chk(f[DW+1] == ^e.d, "R3", "parity bit", int'(f[DW+1]), int'(^e.d));
        chk(f[FB-1:FB-2] == 2'b11, "R2", "stop bits", int'(f[FB-1:FB-2]), 3);
        @(negedge clk);
        if (e.exp) begin
          chk(line_oe && line, "R4", "hold idle bit", int'({line_oe, line}), 3);
          @(negedge clk);
          chk(!line_oe, "R4", "release after hold", int'(line_oe), 0);
        end else
          chk(line_oe && tx_ready, "R4", "keep line, ready", int'({line_oe, tx_ready}), 3);
      end
    end
  end

  logic [DW:0] rexp;
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) chk(0, "R10", "unexpected rx_valid", int'(rx_data), 0);
      else begin
        rexp = rxq.pop_front();
        chk(rx_data == rexp[DW-1:0], "R6", "rx data", int'(rx_data), int'(rexp[DW-1:0]));
        chk(rx_perr == rexp[DW], "R7", "parity error flag", int'(rx_perr), int'(rexp[DW]));
      end
    end
  end

  task automatic send(input logic [DW-1:0] d, input logic e);
    txe_t it;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    it.d = d; it.exp = e; txq.push_back(it);
    tx_valid = 1'b1; tx_data = d; tx_expect = e;
    @(negedge clk);
    tx_valid = 1'b0; tx_expect = 1'b0;
  endtask

  // target model: wait for release, idle bits, then raw frame bits (bit 0 first)
  task automatic drive_raw(input logic [FB-1:0] f, input int idle_n);
    do @(negedge clk); while (line_oe);
    for (int k = 0; k < idle_n; k++) begin line_in = 1'b1; @(negedge clk); end
    chk(!line_oe, "R5", "line still released after target idle bits", int'(line_oe), 0);
    for (int k = 0; k < FB; k++) begin line_in = f[k]; @(negedge clk); end
    line_in = 1'b1;
  endtask

  task automatic reply(input logic [DW-1:0] d, input logic bad_par, input int idle_n);
    rxq.push_back({bad_par, d});
    drive_raw({2'b11, (^d) ^ bad_par, d, 1'b0}, idle_n);
  endtask

  // call in the first cycle after the host took the line back
  task automatic measure_guard(input int g);
    int n = 0;
    chk(line_oe && line, "R9", "host drives idle on regain", int'({line_oe, line}), 3);
    while (!tx_ready && n < 20) begin n++; @(negedge clk); end
    chk(n == g, "R9", "guard length", n, g);
  endtask

  task automatic drain();
    while (txq.size() != 0 || !tx_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    chk(line_oe && line && tx_ready && !rx_valid && !timeout && !brk, "R1", "outputs in reset",
        int'({line_oe, line, tx_ready, rx_valid, timeout, brk}), 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_oe && line && tx_ready && !rx_valid && !timeout && !brk, "R1", "outputs after reset",
        int'({line_oe, line, tx_ready, rx_valid, timeout, brk}), 6'b111000);

    // plain commands, back to back
    send(8'hA5, 0); send(8'h3C, 0); send(8'h00, 0); send(8'hFF, 0);
    drain();

    // reply with target guard, host guard 3; tx_valid ignored while released (R11)
    guard = 3'd3;
    send(8'h5A, 1);
    do @(negedge clk); while (line_oe);
    tx_valid = 1'b1; tx_data = 8'hEE;
    chk(!tx_ready, "R11", "ready low while listening", int'(tx_ready), 0);
    @(negedge clk); tx_valid = 1'b0;
    reply(8'h96, 0, 2);
    measure_guard(3);
    drain();

    // guard 0 behaves as 1; injected parity error (R7)
    guard = 3'd0;
    send(8'h01, 1);
    reply(8'h80, 1, 0);
    measure_guard(1);
    drain();

    // long target idle, guard 7
    guard = 3'd7;
    send(8'h7E, 1);
    reply(8'hC3, 0, 5);
    measure_guard(7);
    drain();

    // no reply: timeout
    guard = 3'd2;
    send(8'h11, 1);
    do @(negedge clk); while (line_oe);
    n = 0;
    while (!line_oe && n < TO + 10) begin n++; @(negedge clk); end
    chk(n == TO, "R8", "release length before timeout", n, TO);
    chk(timeout, "R8", "timeout pulse on regain", int'(timeout), 1);
    measure_guard(2);
    chk(!timeout, "R8", "timeout is a single pulse", int'(timeout), 0);
    drain();

    // low first stop bit: no rx_valid, no break
    send(8'h22, 1);
    drive_raw({1'b1, 1'b0, 1'b0, 8'h55, 1'b0}, 1);
    chk(!brk, "R10", "no break on framing error", int'(brk), 0);
    measure_guard(2);
    drain();

    // all-low frame: BREAK
    send(8'h33, 1);
    drive_raw('0, 0);
    chk(brk, "R10", "break set", int'(brk), 1);
    measure_guard(2);
    repeat (5) @(negedge clk);
    chk(brk, "R10", "break sticky", int'(brk), 1);
    brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0;
    chk(!brk, "R10", "break cleared", int'(brk), 0);

    send(8'h42, 0);
    drain();
    chk(rxq.size() == 0, "R6", "all replies delivered", rxq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule